// File: doc/BRIEF.md
# Fixed-Priority Memory Bus Arbiter

This block hands a shared external memory bus to one of three requesters: a display DMA engine, a DRAM refresh controller and a processor core. Each requester raises a request together with a target class and a transfer length. The target class is either a DRAM bank or a ROM/expansion bank. The arbiter decides only while the bus is idle. The winner then keeps the bus until its transfer completes, and no later request of higher priority can take the bus away mid-transfer.

The priority order is fixed: the DMA engine first, then refresh, then the processor. A transfer to a DRAM bank runs for its full requested length. A transfer to an expansion bank is cut to at most four bus cycles; a requester that needs more must ask again and compete afresh. The block drives a strobe on every granted bus cycle and a one-cycle completion flag on the last one. It then leaves one idle cycle before the next decision. Memory timing, address decoding and data paths are handled elsewhere.

Top module: `memarb_top`

## Requirements
- R1: At most one grant output is high in any cycle; after reset all grants, the strobe and the done flag are low.
- R2: When several requests are sampled in the same idle cycle, the DMA request wins over refresh, and refresh wins over the processor.
- R3: A grant is held unchanged for every cycle of the transfer; a request arriving during a transfer never ends or moves the grant.
- R4: The length field encodes cycles minus one (0 means 1 cycle, 15 means 16 cycles); a DRAM transfer (target bit 0) lasts exactly length+1 granted cycles.
- R5: An expansion transfer (target bit 1) lasts min(length+1, 4) granted cycles.
- R6: A request sampled high at the clock edge that ends an idle cycle produces its grant in the very next cycle.
- R7: The done flag is high for exactly one cycle, the last granted cycle of each transfer.
- R8: The cycle after done has no grant; the next grant comes no earlier than one cycle after that.
- R9: The bus strobe is high exactly in the cycles in which some grant is high.
- R10: A request dropped before the arbiter samples it in an idle cycle is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaReq | input | 1 | DMA engine request |
| dmaTgt | input | 1 | DMA target class: 0 DRAM, 1 expansion |
| dmaLen | input | LEN_W | DMA transfer length minus one |
| refReq | input | 1 | Refresh controller request |
| refTgt | input | 1 | Refresh target class: 0 DRAM, 1 expansion |
| refLen | input | LEN_W | Refresh transfer length minus one |
| cpuReq | input | 1 | Processor request |
| cpuTgt | input | 1 | Processor target class: 0 DRAM, 1 expansion |
| cpuLen | input | LEN_W | Processor transfer length minus one |
| dmaGnt | output | 1 | Bus granted to the DMA engine |
| refGnt | output | 1 | Bus granted to refresh |
| cpuGnt | output | 1 | Bus granted to the processor |
| busStrobe | output | 1 | High on every granted bus cycle |
| xferDone | output | 1 | High on the last cycle of a transfer |

## Verification
The assertions check on every cycle that at most one grant is high, that the grant is stable through a transfer, and that the strobe matches the grant. They also check that done is a single pulse followed by a grant-free cycle, that a new grant goes only to a requester that was asking and that no higher-priority requester was asking, and that an expansion transfer never passes four cycles. The exact length of a DRAM transfer, the one-cycle grant latency and the silent loss of a request withdrawn in time can only be shown by the bench's scenarios. These run against a cycle-level reference model and measure grant lengths and latencies directly.

// File: rtl/memarb_pkg.sv
package memarb_pkg;
  // Target class carried with each request
  typedef enum logic {
    TGT_DRAM = 1'b0,
    TGT_EXP  = 1'b1
  } tgt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the winner and its length
    logic step;   // one granted bus cycle elapses
  } ctrl_s;
endpackage

// File: rtl/memarb_ctrl.sv
module memarb_ctrl
  import memarb_pkg::*;
#(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NREQ-1:0] reqVec,
  input  logic            lastBeat,
  output ctrl_s           strb,
  output logic [NREQ-1:0] winner,
  output logic            busy
);
  typedef enum logic {ST_IDLE, ST_XFER} st_e;
  st_e st, stNext;

  // Fixed priority: lowest index wins
  always_comb begin
    logic found;
    found  = 1'b0;
    winner = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (reqVec[i] && !found) begin
        winner[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    stNext = st;
    strb   = '0;
    case (st)
      ST_IDLE: begin
        if (|reqVec) begin
          strb.load = 1'b1;
          stNext    = ST_XFER;
        end
      end
      ST_XFER: begin
        strb.step = 1'b1;
        if (lastBeat) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign busy = (st == ST_XFER);
endmodule

// File: rtl/memarb_dp.sv
module memarb_dp
  import memarb_pkg::*;
#(
  parameter int NREQ    = 3,
  parameter int LEN_W   = 4,
  parameter int EXP_CAP = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_s                      strb,
  input  logic [NREQ-1:0]            winner,
  input  logic [NREQ-1:0]            tgtVec,
  input  logic [NREQ-1:0][LEN_W-1:0] lenVec,
  output logic [NREQ-1:0]            gntVec,
  output logic                       lastBeat
);
  localparam logic [LEN_W-1:0] CAP_M1 = LEN_W'(EXP_CAP - 1);

  logic             selTgt;
  logic [LEN_W-1:0] selLen;
  logic [LEN_W-1:0] effLen;
  logic [LEN_W-1:0] remain;

  // One-hot select of the winner's target and length
  always_comb begin
    selTgt = 1'b0;
    selLen = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (winner[i]) begin
        selTgt = selTgt | tgtVec[i];
        selLen = selLen | lenVec[i];
      end
    end
  end

  // Expansion bursts are capped; DRAM bursts run their full length
  always_comb begin
    if (selTgt == logic'(TGT_EXP) && selLen > CAP_M1) effLen = CAP_M1;
    else                                               effLen = selLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntVec <= '0;
      remain <= '0;
    end else if (strb.load) begin
      gntVec <= winner;
      remain <= effLen;
    end else if (strb.step) begin
      if (remain == '0) gntVec <= '0;
      else              remain <= remain - 1'b1;
    end
  end

  assign lastBeat = (|gntVec) && (remain == '0);
endmodule

// File: rtl/memarb_top.sv
module memarb_top
  import memarb_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int EXP_CAP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dmaReq,
  input  logic             dmaTgt,
  input  logic [LEN_W-1:0] dmaLen,
  input  logic             refReq,
  input  logic             refTgt,
  input  logic [LEN_W-1:0] refLen,
  input  logic             cpuReq,
  input  logic             cpuTgt,
  input  logic [LEN_W-1:0] cpuLen,
  output logic             dmaGnt,
  output logic             refGnt,
  output logic             cpuGnt,
  output logic             busStrobe,
  output logic             xferDone
);
  localparam int NREQ = 3;

  logic [NREQ-1:0]            reqVec;
  logic [NREQ-1:0]            tgtVec;
  logic [NREQ-1:0][LEN_W-1:0] lenVec;
  logic [NREQ-1:0]            winner;
  logic [NREQ-1:0]            gntVec;
  logic                       lastBeat;
  logic                       busy;
  ctrl_s                      strb;

  // Index 0 has the highest priority
  assign reqVec = {cpuReq, refReq, dmaReq};
  assign tgtVec = {cpuTgt, refTgt, dmaTgt};
  assign lenVec = {cpuLen, refLen, dmaLen};

  memarb_ctrl #(.NREQ(NREQ)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .lastBeat(lastBeat),
    .strb(strb), .winner(winner), .busy(busy)
  );

  memarb_dp #(.NREQ(NREQ), .LEN_W(LEN_W), .EXP_CAP(EXP_CAP)) dpInst (
    .clk(clk), .rstN(rstN), .strb(strb), .winner(winner),
    .tgtVec(tgtVec), .lenVec(lenVec), .gntVec(gntVec), .lastBeat(lastBeat)
  );

  assign {cpuGnt, refGnt, dmaGnt} = gntVec;
  assign busStrobe = busy;
  assign xferDone  = lastBeat;
endmodule

// File: rtl/memarb_chk.sv
module memarb_chk #(
  parameter int EXP_CAP = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] reqVec,
  input logic [2:0] tgtVec,
  input logic [2:0] gntVec,
  input logic       busStrobe,
  input logic       xferDone
);
  logic [2:0] tgtPrev;
  logic [2:0] gntPrev;
  logic [7:0] beatReg;
  logic       expReg;
  logic       rise;
  logic       expNow;

  assign rise   = (|gntVec) && !(|gntPrev);
  assign expNow = rise ? |(tgtPrev & gntVec) : expReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtPrev <= '0;
      gntPrev <= '0;
      beatReg <= '0;
      expReg  <= 1'b0;
    end else begin
      tgtPrev <= tgtVec;
      gntPrev <= gntVec;
      expReg  <= expNow;
      beatReg <= (|gntVec) ? beatReg + 8'd1 : 8'd0;
    end
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));

  // R9
  strobe_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe == (|gntVec));

  // R7
  done_in_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (|gntVec));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|gntVec) && !xferDone) |=> (gntVec == $past(gntVec)));

  // R8
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> (gntVec == 3'b000));

  // R6
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rise |-> (|($past(reqVec) & gntVec)));

  // R2
  dma_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rise && $past(reqVec[0])) |-> gntVec[0]);

  // R2
  ref_over_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rise && $past(reqVec[1]) && !$past(reqVec[0])) |-> gntVec[1]);

  // R5
  exp_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|gntVec) && expNow) |-> (beatReg < 8'(EXP_CAP)));
endmodule

bind memarb_top memarb_chk #(.EXP_CAP(EXP_CAP)) chkInst (
  .clk(clk), .rstN(rstN), .reqVec(reqVec), .tgtVec(tgtVec),
  .gntVec(gntVec), .busStrobe(busStrobe), .xferDone(xferDone)
);

// File: tb/memarb_top_test.sv
module memarb_top_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [2:0] reqV;
  logic [2:0] tgtV;
  logic [3:0] lenV [3];
  logic       dmaGnt, refGnt, cpuGnt, busStrobe, xferDone;
  logic [2:0] gntV;

  int  nChk = 0;
  int  nBad = 0;
  bit  chkOn = 1'b0;

  // Reference model state
  bit  mBusy = 1'b0;
  int  mWho = 0;
  int  mLeft = 0;

  memarb_top uut (
    .clk(clk), .rstN(rstN),
    .dmaReq(reqV[0]), .dmaTgt(tgtV[0]), .dmaLen(lenV[0]),
    .refReq(reqV[1]), .refTgt(tgtV[1]), .refLen(lenV[1]),
    .cpuReq(reqV[2]), .cpuTgt(tgtV[2]), .cpuLen(lenV[2]),
    .dmaGnt(dmaGnt), .refGnt(refGnt), .cpuGnt(cpuGnt),
    .busStrobe(busStrobe), .xferDone(xferDone)
  );

  assign gntV = {cpuGnt, refGnt, dmaGnt};

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Granted cycles: full length for DRAM, at most 4 for expansion
  function automatic int burstCycles(input logic tgt, input logic [3:0] len);
    int n;
    n = int'(len) + 1;
    if (tgt && n > 4) n = 4;
    return n;
  endfunction

  function automatic int pickWinner(input logic [2:0] r);
    if (r[0]) return 0;
    if (r[1]) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) mBusy = 1'b0;
    else if (mBusy) begin
      if (mLeft == 0) mBusy = 1'b0;
      else            mLeft--;
    end else if (reqV != 3'b000) begin
      mWho  = pickWinner(reqV);
      mLeft = burstCycles(tgtV[mWho], lenV[mWho]) - 1;
      mBusy = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (chkOn) begin
      check("R1 R2 R3 R6 R8 R10 grant vector", int'(gntV),
            mBusy ? (1 << mWho) : 0);
      check("R9 strobe", int'(busStrobe), int'(mBusy));
      check("R4 R5 R7 done", int'(xferDone), int'(mBusy && mLeft == 0));
    end
  end

  task automatic ask(input int i, input logic t, input logic [3:0] l);
    reqV[i] = 1'b1;
    tgtV[i] = t;
    lenV[i] = l;
  endtask

  // Wait for requester i's grant, drop its request, count granted cycles
  task automatic measure(input int i, output int lat, output int beats);
    lat = 0;
    beats = 0;
    while (!gntV[i] && lat <= 40) begin
      @(negedge clk);
      lat++;
    end
    reqV[i] = 1'b0;
    while (gntV[i] && beats <= 40) begin
      beats++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R3 R7: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int lat, beats, cnt;
    void'($urandom(32'h00C0FFEE));
    rstN = 1'b0;
    reqV = '0;
    tgtV = '0;
    for (int i = 0; i < 3; i++) lenV[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset grants", int'(gntV), 0);
    check("R1 reset strobe", int'(busStrobe), 0);
    check("R1 reset done", int'(xferDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkOn = 1'b1;

    // R4 longest DRAM burst, R6 latency
    ask(2, 1'b0, 4'd15);
    measure(2, lat, beats);
    check("R6 latency", lat, 1);
    check("R4 dram 16 cycles", beats, 16);

    // R5 long expansion request is capped
    ask(1, 1'b1, 4'd9);
    measure(1, lat, beats);
    check("R5 exp capped", beats, 4);

    // R5 short expansion request runs in full
    ask(0, 1'b1, 4'd1);
    measure(0, lat, beats);
    check("R5 exp short", beats, 2);

    // R4 shortest DRAM burst
    ask(2, 1'b0, 4'd0);
    measure(2, lat, beats);
    check("R4 dram 1 cycle", beats, 1);

    // R2 all three at once, R8 one idle cycle between transfers
    ask(0, 1'b0, 4'd2);
    ask(1, 1'b1, 4'd5);
    ask(2, 1'b0, 4'd1);
    measure(0, lat, beats);
    check("R2 dma first latency", lat, 1);
    check("R2 dma beats", beats, 3);
    measure(1, lat, beats);
    check("R8 gap before refresh", lat, 1);
    check("R2 refresh second beats", beats, 4);
    measure(2, lat, beats);
    check("R8 gap before cpu", lat, 1);
    check("R2 cpu last beats", beats, 2);

    // R3 no preemption by a later DMA request
    ask(2, 1'b0, 4'd7);
    @(negedge clk);
    check("R6 cpu granted", int'(gntV), 4);
    reqV[2] = 1'b0;
    ask(0, 1'b0, 4'd0);
    cnt = 0;
    while (cpuGnt && cnt <= 40) begin
      cnt++;
      @(negedge clk);
    end
    check("R3 cpu kept bus", cnt, 8);
    measure(0, lat, beats);
    check("R3 dma after cpu", lat, 1);

    // R10 request withdrawn while bus busy is never granted
    ask(0, 1'b0, 4'd9);
    @(negedge clk);
    reqV[0] = 1'b0;
    ask(2, 1'b0, 4'd0);
    repeat (3) @(negedge clk);
    reqV[2] = 1'b0;
    cnt = 0;
    repeat (20) begin
      @(negedge clk);
      if (cpuGnt) cnt++;
    end
    check("R10 cancelled request", cnt, 0);

    // Random traffic checked against the model
    repeat (4000) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (gntV[i]) reqV[i] = 1'b0;
        else if (reqV[i] && ($urandom % 20) == 0) reqV[i] = 1'b0;
        else if (!reqV[i] && ($urandom % 4) == 0)
          ask(i, logic'($urandom % 2), 4'($urandom % 16));
      end
    end
    reqV = '0;
    repeat (40) @(negedge clk);
    check("R1 quiet at end", int'(gntV), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule